// File: doc/BRIEF.md
# UART Transmitter with Priority Character Injection

This block is the transmit side of a UART. Bytes written by a host through a small register interface wait in a byte FIFO. A serializer sends them out one character at a time: a start bit, 5 to 8 data bits sent LSB first, an optional parity bit, and one or two stop bits. Each bit lasts a parameterized number of baud ticks. The baud tick comes from a divider outside the block. The only part of the receiver this block sees is a received-character strobe.

Before each load, a selector decides which character goes next. Software flow-control characters (the resume and pause codes) win first. Next comes a single urgent byte, which the host sends by arming a control bit and then writing the holding register. The head of the FIFO comes last. The character already being sent is never cut short. Flow control works on received characters: a received pause code stops ordinary FIFO traffic. Either a matching resume code or, when the any-character resume option is on, any received character starts it again. Flow-control characters and the urgent byte are still sent while FIFO traffic is stopped.

Top module: `uart_tx_inject`

## Requirements
- R1: A frame is a low start bit, then `5 + data_len` data bits (data_len 0..3) LSB first, then a parity bit if enabled, then one stop bit (two if stop_two=1), all high. Each bit lasts OSR cycles of baud_tick. The line is high whenever no frame is in progress. FIFO bytes go out in the order they were written.
- R2: With parity_on=1, the parity bit equals the XOR of the transmitted data bits when parity_even=1, and its complement when parity_even=0.
- R3: A host write to address 1 with bit 0 set arms urgent mode, shown on urgent_armed. The next write to address 0 (holding register) is captured as the urgent byte and is not queued, and urgent_armed returns to 0 on its own.
- R4: The urgent byte starts after the character in progress completes, ahead of every byte waiting in the FIFO, and uses the current line settings.
- R5: While armed, a write to any address other than 0 cancels urgent mode, except a re-arming write to address 1 with bit 0 set. A later write to address 0 is then queued in the FIFO as normal.
- R6: A pending pause request (send_xoff) or resume request (send_xon) is sent before the urgent byte, with pause ahead of resume. The resume code is held at address 2 (reset 0x11) and the pause code at address 3 (reset 0x13).
- R7: A new character is loaded only when the serializer is idle. Nothing is loaded while tx_enable=0, and a frame already in progress still completes.
- R8: With flow_ctl_en=1, receiving the pause code sets flow_halted. The line then stays high with FIFO bytes still queued, but flow-control characters and the urgent byte are still sent. Setting flow_ctl_en=0 clears the halt.
- R9: With xon_any=0, only a received resume code clears flow_halted. With xon_any=1, any received character clears it, except a received pause code, which still halts.
- R10: The FIFO holds FIFO_DEPTH bytes. fifo_full is 1 when it is full, and a write to address 0 while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register address: 0 holding, 1 control, 2 resume code, 3 pause code |
| host_wdata | input | 8 | Write data |
| tx_enable | input | 1 | Allows new characters to be loaded |
| data_len | input | 2 | Data bits minus 5 |
| parity_on | input | 1 | Adds a parity bit |
| parity_even | input | 1 | 1 even parity, 0 odd parity |
| stop_two | input | 1 | 1 selects two stop bits |
| baud_tick | input | 1 | Oversampling tick, OSR per bit |
| send_xon | input | 1 | Pulse: request one resume code |
| send_xoff | input | 1 | Pulse: request one pause code |
| flow_ctl_en | input | 1 | Enables halting on received pause code |
| xon_any | input | 1 | Any received character resumes |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | 8 | Received character |
| txd | output | 1 | Serial output, idle high |
| fifo_full | output | 1 | FIFO full |
| urgent_armed | output | 1 | Urgent mode armed |
| flow_halted | output | 1 | FIFO traffic paused by flow control |

## Verification
The bench builds the block with OSR=4 and FIFO_DEPTH=4, with baud_tick held high. Each bit then lasts four clocks, so a frame fits in a few dozen cycles and many orderings can be decoded within the run. Four writes fill the FIFO, which brings the full flag and the dropped write within easy reach. Holding tx_enable low while bytes are queued sets up a known character in progress, so the bench can place the urgent byte and the flow-control requests exactly behind it.

// File: rtl/uit_pkg.sv
// Package: shared constants and types for the injecting UART transmitter.
// Assumes 8-bit characters; the data-length code selects 5..8 of them.
package uit_pkg;
    localparam int UIT_DW = 8;
    localparam int UIT_FW = UIT_DW + 4;   // start + data + parity + 2 stop

    localparam logic [1:0] ADDR_HOLD = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_XON  = 2'd2;
    localparam logic [1:0] ADDR_XOFF = 2'd3;

    localparam logic [7:0] XON_RESET  = 8'h11;
    localparam logic [7:0] XOFF_RESET = 8'h13;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_FLOW   = 2'd1,
        SRC_URGENT = 2'd2,
        SRC_FIFO   = 2'd3
    } uit_src_e;
endpackage

// File: rtl/uit_fifo.sv
// Module: byte FIFO holding normal transmit traffic.
// Assumes DEPTH >= 2; push while full and pop while empty are ignored.
module uit_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uit_host.sv
// Module: host register decode, urgent-byte arming and the urgent slot.
// Assumes one write per strobe cycle; any write other than a re-arm
// or the holding write cancels an armed urgent send.
module uit_host
    import uit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [1:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic        fifo_push,
    output logic [7:0]  fifo_din,
    input  logic        urg_take,
    output logic        urg_valid,
    output logic [7:0]  urg_data,
    output logic        armed,
    output logic [7:0]  xon_char,
    output logic [7:0]  xoff_char
);
    logic hold_wr;

    assign hold_wr   = host_wr && (host_addr == ADDR_HOLD);
    assign fifo_push = hold_wr && !armed;
    assign fifo_din  = host_wdata;

    // Arming state: set by control bit 0, cleared by any other write.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (host_wr) armed <= (host_addr == ADDR_CTRL) && host_wdata[0];
    end

    // Urgent slot: captured by an armed holding write, freed when loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            urg_valid <= 1'b0;
            urg_data  <= '0;
        end else if (hold_wr && armed) begin
            urg_valid <= 1'b1;
            urg_data  <= host_wdata;
        end else if (urg_take) begin
            urg_valid <= 1'b0;
        end
    end

    // Flow-control character registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xon_char  <= XON_RESET;
            xoff_char <= XOFF_RESET;
        end else if (host_wr) begin
            if (host_addr == ADDR_XON)  xon_char  <= host_wdata;
            if (host_addr == ADDR_XOFF) xoff_char <= host_wdata;
        end
    end
endmodule

// File: rtl/uit_flow.sv
// Module: software flow-control state: halt flag and pending requests.
// Assumes request pulses and received strobes last one cycle each;
// a request arriving in the cycle its character is taken stays pending.
module uit_flow (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flow_en,
    input  logic       xon_any,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic [7:0] xon_char,
    input  logic [7:0] xoff_char,
    input  logic       req_xon,
    input  logic       req_xoff,
    input  logic       take_xon,
    input  logic       take_xoff,
    output logic       halted,
    output logic       xon_pend,
    output logic       xoff_pend
);
    // Halt flag driven by received characters.
    always_ff @(posedge clk) begin
        if (!rst_n || !flow_en) begin
            halted <= 1'b0;
        end else if (rx_valid) begin
            if (rx_data == xoff_char)                   halted <= 1'b1;
            else if (xon_any || (rx_data == xon_char))  halted <= 1'b0;
        end
    end

    // Pending flags for flow-control characters to send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xon_pend  <= 1'b0;
            xoff_pend <= 1'b0;
        end else begin
            xon_pend  <= req_xon  || (xon_pend  && !take_xon);
            xoff_pend <= req_xoff || (xoff_pend && !take_xoff);
        end
    end
endmodule

// File: rtl/uit_shifter.sv
// Module: frame builder and serializer.
// Assumes load arrives only while idle; line settings are captured at load.
module uit_shifter
    import uit_pkg::*;
#(
    parameter int OSR  = 16,
    localparam int SW  = (OSR > 1) ? $clog2(OSR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             load,
    input  logic [UIT_DW-1:0] ld_data,
    input  logic [1:0]       data_len,
    input  logic             par_en,
    input  logic             par_even,
    input  logic             stop2,
    output logic             busy,
    output logic             txd
);
    logic [UIT_FW-1:0] frame, shreg;
    logic [3:0]        nbits, bits_left;
    logic [SW-1:0]     sub;

    // Frame assembly from data, length and parity settings.
    always_comb begin
        int  n;
        logic p;
        n     = 5 + int'(data_len);
        frame = '1;
        frame[0] = 1'b0;
        p = 1'b0;
        for (int i = 0; i < UIT_DW; i++) begin
            if (i < n) begin
                frame[1 + i] = ld_data[i];
                p = p ^ ld_data[i];
            end
        end
        if (par_en) frame[1 + n] = par_even ? p : ~p;
        nbits = 4'(1 + n + (par_en ? 1 : 0) + (stop2 ? 2 : 1));
    end

    assign txd = busy ? shreg[0] : 1'b1;

    // Bit timing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            shreg     <= '1;
            bits_left <= '0;
            sub       <= '0;
        end else if (load && !busy) begin
            busy      <= 1'b1;
            shreg     <= frame;
            bits_left <= nbits;
            sub       <= '0;
        end else if (busy && baud_tick) begin
            if (sub == SW'(OSR - 1)) begin
                sub       <= '0;
                shreg     <= {1'b1, shreg[UIT_FW-1:1]};
                bits_left <= bits_left - 1'b1;
                if (bits_left == 4'd1) busy <= 1'b0;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_tx_inject.sv
// Module: top of the injecting UART transmitter; holds the load arbiter.
// Assumes baud_tick comes from an external divider at OSR per bit.
module uart_tx_inject
    import uit_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OSR        = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       tx_enable,
    input  logic [1:0] data_len,
    input  logic       parity_on,
    input  logic       parity_even,
    input  logic       stop_two,
    input  logic       baud_tick,
    input  logic       send_xon,
    input  logic       send_xoff,
    input  logic       flow_ctl_en,
    input  logic       xon_any,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       txd,
    output logic       fifo_full,
    output logic       urgent_armed,
    output logic       flow_halted
);
    logic             fifo_push, fifo_pop, fifo_empty;
    logic [7:0]       fifo_din, fifo_dout;
    logic [CNT_W-1:0] fifo_cnt;
    logic             urg_valid, urg_take;
    logic [7:0]       urg_data, xon_char, xoff_char;
    logic             xon_pend, xoff_pend, take_xon, take_xoff;
    logic             sh_busy, ld_go;
    logic [7:0]       ld_data;
    uit_src_e         ld_src;

    uit_host u_host (
        .clk, .rst_n, .host_wr, .host_addr, .host_wdata,
        .fifo_push, .fifo_din, .urg_take, .urg_valid, .urg_data,
        .armed(urgent_armed), .xon_char, .xoff_char
    );

    uit_fifo #(.DEPTH(FIFO_DEPTH), .DW(UIT_DW)) u_fifo (
        .clk, .rst_n, .push(fifo_push), .din(fifo_din), .pop(fifo_pop),
        .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full), .count(fifo_cnt)
    );

    uit_flow u_flow (
        .clk, .rst_n, .flow_en(flow_ctl_en), .xon_any, .rx_valid, .rx_data,
        .xon_char, .xoff_char, .req_xon(send_xon), .req_xoff(send_xoff),
        .take_xon, .take_xoff, .halted(flow_halted), .xon_pend, .xoff_pend
    );

    // Load arbiter: flow characters, then urgent byte, then FIFO head.
    always_comb begin
        ld_src    = SRC_NONE;
        ld_data   = fifo_dout;
        take_xon  = 1'b0;
        take_xoff = 1'b0;
        urg_take  = 1'b0;
        fifo_pop  = 1'b0;
        if (tx_enable && !sh_busy) begin
            if (xoff_pend) begin
                ld_src    = SRC_FLOW;
                ld_data   = xoff_char;
                take_xoff = 1'b1;
            end else if (xon_pend) begin
                ld_src   = SRC_FLOW;
                ld_data  = xon_char;
                take_xon = 1'b1;
            end else if (urg_valid) begin
                ld_src   = SRC_URGENT;
                ld_data  = urg_data;
                urg_take = 1'b1;
            end else if (!flow_halted && !fifo_empty) begin
                ld_src   = SRC_FIFO;
                fifo_pop = 1'b1;
            end
        end
    end

    assign ld_go = (ld_src != SRC_NONE);

    uit_shifter #(.OSR(OSR)) u_shift (
        .clk, .rst_n, .baud_tick, .load(ld_go), .ld_data,
        .data_len, .par_en(parity_on), .par_even(parity_even), .stop2(stop_two),
        .busy(sh_busy), .txd
    );
endmodule

// File: rtl/uit_checks.sv
// Module: assertion checker bound to the top of the injecting transmitter.
module uit_checks
    import uit_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_enable,
    input logic             txd,
    input logic             sh_busy,
    input logic             ld_go,
    input uit_src_e         ld_src,
    input logic             xon_pend,
    input logic             xoff_pend,
    input logic             urg_valid,
    input logic             flow_halted,
    input logic             fifo_full,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             host_wr,
    input logic [1:0]       host_addr,
    input logic [7:0]       host_wdata,
    input logic             urgent_armed
);
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_busy |-> txd);  // R1
    AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |=> (!txd && sh_busy));  // R1
    AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && urgent_armed && host_addr == ADDR_HOLD) |=> !urgent_armed);  // R3
    AST_URGENT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_go && urg_valid && !xon_pend && !xoff_pend) |-> ld_src == SRC_URGENT);  // R4
    AST_ARM_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr != ADDR_HOLD && !(host_addr == ADDR_CTRL && host_wdata[0]))
        |=> !urgent_armed);  // R5
    AST_FLOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_go && (xon_pend || xoff_pend)) |-> ld_src == SRC_FLOW);  // R6
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |-> !sh_busy);  // R7
    AST_NO_LOAD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> !ld_go);  // R7
    AST_HALT_HOLDS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_halted && ld_go) |-> ld_src != SRC_FIFO);  // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |=> fifo_cnt <= $past(fifo_cnt));  // R10
endmodule

bind uart_tx_inject uit_checks #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .txd(txd),
    .sh_busy(sh_busy), .ld_go(ld_go), .ld_src(ld_src),
    .xon_pend(xon_pend), .xoff_pend(xoff_pend), .urg_valid(urg_valid),
    .flow_halted(flow_halted), .fifo_full(fifo_full), .fifo_cnt(fifo_cnt),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .urgent_armed(urgent_armed)
);

// File: tb/sim_uart_tx_inject.sv
// Bench: scoreboard of expected characters, serial monitor decoding txd.
module sim_uart_tx_inject;
    localparam int OSR   = 4;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       tx_enable = 1'b0;
    logic [1:0] data_len = 2'd3;
    logic       parity_on = 1'b0, parity_even = 1'b0, stop_two = 1'b0;
    logic       send_xon = 1'b0, send_xoff = 1'b0;
    logic       flow_ctl_en = 1'b0, xon_any = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       txd, fifo_full, urgent_armed, flow_halted;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    uart_tx_inject #(.FIFO_DEPTH(DEPTH), .OSR(OSR)) u0 (
        .clk, .rst_n, .host_wr, .host_addr, .host_wdata, .tx_enable,
        .data_len, .parity_on, .parity_even, .stop_two, .baud_tick(1'b1),
        .send_xon, .send_xoff, .flow_ctl_en, .xon_any, .rx_valid, .rx_data,
        .txd, .fifo_full, .urgent_armed, .flow_halted
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic expect_char(input logic [7:0] d, input string req);
        exp_q.push_back(d & 8'((1 << (5 + int'(data_len))) - 1));
        tag_q.push_back(req);
    endtask

    task automatic rx_char(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        repeat (3 * OSR) @(negedge clk);
    endtask

    task automatic expect_quiet(input int n, input string req);
        int lows = 0;
        repeat (n) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        chk(lows == 0, req, lows, 0);
    endtask

    // Monitor: decodes each frame and compares it with the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd == 1'b0) begin
                int n;
                logic [7:0] got;
                logic pb, pexp;
                string req;
                n = 5 + int'(data_len);
                got = '0;
                repeat (OSR / 2) @(negedge clk);
                chk(txd == 1'b0, "R1 start bit", txd, 0);
                for (int i = 0; i < n; i++) begin
                    repeat (OSR) @(negedge clk);
                    got[i] = txd;
                end
                if (parity_on) begin
                    repeat (OSR) @(negedge clk);
                    pb = txd;
                    pexp = parity_even ? ^got : ~^got;
                    chk(pb == pexp, "R2 parity bit", pb, pexp);
                end
                for (int s = 0; s < (stop_two ? 2 : 1); s++) begin
                    repeat (OSR) @(negedge clk);
                    chk(txd == 1'b1, "R1 stop bit", txd, 1);
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1/R7 unexpected frame", got, 0);
                end else begin
                    req = tag_q.pop_front();
                    chk(got == exp_q[0], req, got, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                chk(1'b0, "watchdog", cycles, 150000);
                finish_run();
            end
        end
    end

    // Stimulus.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(txd == 1'b1, "R1 reset idle high", txd, 1);
        chk(urgent_armed == 1'b0, "R3 reset not armed", urgent_armed, 0);
        chk(flow_halted == 1'b0, "R8 reset not halted", flow_halted, 0);
        chk(fifo_full == 1'b0, "R10 reset not full", fifo_full, 0);

        // R1: plain FIFO order, 8N1
        tx_enable = 1'b1;
        expect_char(8'hA5, "R1 order 0"); expect_char(8'h3C, "R1 order 1");
        expect_char(8'h0F, "R1 order 2");
        wr(2'd0, 8'hA5); wr(2'd0, 8'h3C); wr(2'd0, 8'h0F);
        drain("R1 drain");

        // R2: 7 bits even parity two stops, then 5 bits odd parity
        data_len = 2'd2; parity_on = 1'b1; parity_even = 1'b1; stop_two = 1'b1;
        expect_char(8'h55, "R2 7E2 a"); expect_char(8'hFE, "R2 7E2 b");
        wr(2'd0, 8'h55); wr(2'd0, 8'hFE);
        drain("R2 drain 7E2");
        data_len = 2'd0; parity_even = 1'b0; stop_two = 1'b0;
        expect_char(8'h13, "R2 5O1 a"); expect_char(8'h16, "R2 5O1 b");
        wr(2'd0, 8'h13); wr(2'd0, 8'h16);
        drain("R2 drain 5O1");
        data_len = 2'd3; parity_on = 1'b0;

        // R3/R4: urgent byte jumps queued bytes, not the one in flight
        tx_enable = 1'b0;
        wr(2'd0, 8'h01); wr(2'd0, 8'h02); wr(2'd0, 8'h03);
        expect_char(8'h01, "R4 in-flight first"); expect_char(8'hEE, "R4 urgent second");
        expect_char(8'h02, "R4 queue after"); expect_char(8'h03, "R4 queue after 2");
        tx_enable = 1'b1;
        repeat (3) @(negedge clk);
        wr(2'd1, 8'h01);
        chk(urgent_armed == 1'b1, "R3 armed", urgent_armed, 1);
        wr(2'd0, 8'hEE);
        chk(urgent_armed == 1'b0, "R3 self clear", urgent_armed, 0);
        drain("R4 drain");

        // R4 with parity: urgent byte uses current line settings
        parity_on = 1'b1; parity_even = 1'b1;
        tx_enable = 1'b0;
        wr(2'd0, 8'h70);
        expect_char(8'h70, "R4 parity in-flight"); expect_char(8'h5B, "R4 urgent parity");
        tx_enable = 1'b1;
        repeat (3) @(negedge clk);
        wr(2'd1, 8'h01); wr(2'd0, 8'h5B);
        drain("R4 drain parity");
        parity_on = 1'b0;

        // R5: another register write cancels the armed mode
        tx_enable = 1'b0;
        wr(2'd0, 8'h21);
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h11);
        chk(urgent_armed == 1'b0, "R5 cancelled", urgent_armed, 0);
        wr(2'd0, 8'h22);
        expect_char(8'h21, "R5 queued first"); expect_char(8'h22, "R5 queued normally");
        tx_enable = 1'b1;
        drain("R5 drain");

        // R6: pause then resume codes go ahead of the urgent byte
        tx_enable = 1'b0;
        wr(2'd0, 8'h31); wr(2'd0, 8'h32);
        expect_char(8'h31, "R6 in-flight"); expect_char(8'h13, "R6 pause code first");
        expect_char(8'h11, "R6 resume code second"); expect_char(8'h7A, "R6 urgent after flow");
        expect_char(8'h32, "R6 queue last");
        tx_enable = 1'b1;
        repeat (3) @(negedge clk);
        send_xon = 1'b1; send_xoff = 1'b1;
        @(negedge clk);
        send_xon = 1'b0; send_xoff = 1'b0;
        wr(2'd1, 8'h01); wr(2'd0, 8'h7A);
        drain("R6 drain");
        wr(2'd3, 8'h93);
        expect_char(8'h93, "R6 pause code register");
        send_xoff = 1'b1;
        @(negedge clk);
        send_xoff = 1'b0;
        drain("R6 drain reg");
        wr(2'd3, 8'h13);

        // R7: nothing loads while disabled
        tx_enable = 1'b0;
        wr(2'd1, 8'h01); wr(2'd0, 8'h44);
        expect_quiet(100, "R7 disabled urgent held");
        expect_char(8'h44, "R7 sent when enabled");
        tx_enable = 1'b1;
        drain("R7 drain");

        // R8: pause halts FIFO traffic but not urgent or flow characters
        flow_ctl_en = 1'b1;
        rx_char(8'h13);
        @(negedge clk);
        chk(flow_halted == 1'b1, "R8 halted", flow_halted, 1);
        wr(2'd0, 8'h51); wr(2'd0, 8'h52);
        expect_quiet(120, "R8 FIFO held");
        expect_char(8'h5A, "R8 urgent while halted");
        wr(2'd1, 8'h01); wr(2'd0, 8'h5A);
        drain("R8 drain urgent");
        expect_char(8'h11, "R8 resume code while halted");
        send_xon = 1'b1;
        @(negedge clk);
        send_xon = 1'b0;
        drain("R8 drain flow");
        expect_quiet(60, "R8 FIFO still held");

        // R9: resume rules
        rx_char(8'h41);
        @(negedge clk);
        chk(flow_halted == 1'b1, "R9 other char no resume", flow_halted, 1);
        expect_quiet(60, "R9 still held");
        xon_any = 1'b1;
        expect_char(8'h51, "R9 resumed 0"); expect_char(8'h52, "R9 resumed 1");
        rx_char(8'h41);
        @(negedge clk);
        chk(flow_halted == 1'b0, "R9 any char resumes", flow_halted, 0);
        drain("R9 drain");
        rx_char(8'h13);
        @(negedge clk);
        chk(flow_halted == 1'b1, "R9 pause still halts", flow_halted, 1);
        xon_any = 1'b0;
        rx_char(8'h11);
        @(negedge clk);
        chk(flow_halted == 1'b0, "R9 resume code", flow_halted, 0);
        rx_char(8'h13);
        flow_ctl_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(flow_halted == 1'b0, "R8 disable clears", flow_halted, 0);

        // R10: full flag and dropped write
        tx_enable = 1'b0;
        wr(2'd0, 8'h61); wr(2'd0, 8'h62); wr(2'd0, 8'h63);
        chk(fifo_full == 1'b0, "R10 not full at depth-1", fifo_full, 0);
        wr(2'd0, 8'h64);
        chk(fifo_full == 1'b1, "R10 full", fifo_full, 1);
        wr(2'd0, 8'h65);
        expect_char(8'h61, "R10 kept 0"); expect_char(8'h62, "R10 kept 1");
        expect_char(8'h63, "R10 kept 2"); expect_char(8'h64, "R10 kept 3");
        tx_enable = 1'b1;
        drain("R10 drain");
        expect_quiet(100, "R10 dropped write not sent");
        chk(fifo_full == 1'b0, "R10 empty after drain", fifo_full, 0);

        finish_run();
    end
endmodule